// File: doc/BRIEF.md
# Midscale-Insertion Rate Doubler

This block sits between a 2x interpolation stage and the 14-bit data port of a DAC. It runs on the DAC's 4x-rate clock, qualified by a phase enable, and turns the interpolated samples into the word the converter sees on each 4x slot. In stuffing mode every real sample is followed by one slot of the midscale code, 0x2000 in offset binary. The DAC output then falls back to zero differential current after each real sample, and its update rate doubles from 2x to 4x the input rate. In pass mode each sample is shown on both 4x slots, so the downstream timing is the same in either mode.

A small state machine walks the slot pair. `ST_IDLE` is the reset state and shows midscale. From `ST_IDLE`, `ST_FILL` or `ST_HOLD`, an enabled tick is an even boundary. There the machine captures the sample and the mode input and moves to `ST_LIVE`, which shows the captured sample. From `ST_LIVE` an enabled tick moves to `ST_FILL` (shows the midscale register) when the captured mode is stuffing, or to `ST_HOLD` (shows the sample again) when it is pass. The output is a two-input multiplexer between the sample register and a register that holds the midscale constant. It switches once per 4x slot.

Top module: `midscale_stuffer`

## Requirements
- R1: While reset is low, and on the first cycle after it, `dac_word` is 0x2000 and the next enabled tick is an even (capture) tick.
- R2: On an enabled even tick with `smp_vld` high, `dac_word` shows `smp_in` from the following cycle on.
- R3: In stuffing mode (captured `stuff_en` = 1), the enabled odd tick after a sample makes `dac_word` 0x2000.
- R4: In pass mode (captured `stuff_en` = 0), the enabled odd tick leaves `dac_word` at the same sample.
- R5: `stuff_en` is sampled only on enabled even ticks. A change between even ticks has no effect on the odd slot that follows.
- R6: An enabled even tick with `smp_vld` low gives 0x2000 on both slots of that pair, in either mode.
- R7: `smp_vld` and `smp_in` are ignored on odd ticks.
- R8: While `clk_en` is low, `dac_word` and the slot phase hold.
- R9: The filler word is always 0x2000, whatever data has passed through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4x-rate DAC clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Slot enable; one 4x slot advances per high cycle |
| smp_in | input | 14 | Interpolated sample, offset binary |
| smp_vld | input | 1 | Sample strobe, used on even ticks |
| stuff_en | input | 1 | 1 = insert midscale after each sample, 0 = repeat each sample |
| dac_word | output | 14 | Word to the DAC |

## Verification
A mode change and a sample capture can fall on the same even tick. The new mode then has to govern the odd slot of the sample captured on that tick, and not the one before it. The bench provokes this by flipping `stuff_en` on an even tick that also carries a new sample. It checks that the odd slot after that tick follows the new mode. A flip of `stuff_en` on an odd tick is also driven; there the check is that the current pair completes unchanged. A stall (`clk_en` low) placed between the two slots of a pair checks that the pairing survives the gap.

// File: rtl/mstuf_pkg.sv
package mstuf_pkg;
    localparam int unsigned WORD_W = 14;
    localparam logic [WORD_W-1:0] MIDSCALE = logic'(1) << (WORD_W - 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LIVE = 2'd1,
        ST_FILL = 2'd2,
        ST_HOLD = 2'd3
    } slot_state_t;
endpackage

// File: rtl/mstuf_slot_fsm.sv
module mstuf_slot_fsm
    import mstuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic mode_q,
    output logic odd_ph,
    output logic pick_data
);
    slot_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_LIVE;
                ST_LIVE: state_d = mode_q ? ST_FILL : ST_HOLD;
                ST_FILL: state_d = ST_LIVE;
                ST_HOLD: state_d = ST_LIVE;
            endcase
        end
    end

    always_comb begin
        odd_ph    = 1'b0;
        pick_data = 1'b0;
        unique case (state_q)
            ST_IDLE: begin odd_ph = 1'b0; pick_data = 1'b0; end
            ST_LIVE: begin odd_ph = 1'b1; pick_data = 1'b1; end
            ST_FILL: begin odd_ph = 1'b0; pick_data = 1'b0; end
            ST_HOLD: begin odd_ph = 1'b0; pick_data = 1'b1; end
        endcase
    end
endmodule

// File: rtl/mstuf_mid_reg.sv
module mstuf_mid_reg
    import mstuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] mid_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) mid_q <= MIDSCALE;
        else        mid_q <= mid_q;
    end
endmodule

// File: rtl/mstuf_capture.sv
module mstuf_capture
    import mstuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              smp_vld,
    input  logic [WORD_W-1:0] smp_in,
    input  logic              stuff_en,
    input  logic [WORD_W-1:0] mid_q,
    output logic [WORD_W-1:0] data_q,
    output logic              mode_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= MIDSCALE;
            mode_q <= 1'b0;
        end else if (load) begin
            data_q <= smp_vld ? smp_in : mid_q;
            mode_q <= stuff_en;
        end
    end
endmodule

// File: rtl/midscale_stuffer.sv
module midscale_stuffer
    import mstuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [WORD_W-1:0] smp_in,
    input  logic              smp_vld,
    input  logic              stuff_en,
    output logic [WORD_W-1:0] dac_word
);
    logic              odd_ph;
    logic              pick_data;
    logic              mode_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] mid_q;
    logic              load;

    assign load = clk_en && !odd_ph;

    mstuf_slot_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (clk_en),
        .mode_q    (mode_q),
        .odd_ph    (odd_ph),
        .pick_data (pick_data)
    );

    mstuf_mid_reg u_mid (
        .clk   (clk),
        .rst_n (rst_n),
        .mid_q (mid_q)
    );

    mstuf_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .smp_vld  (smp_vld),
        .smp_in   (smp_in),
        .stuff_en (stuff_en),
        .mid_q    (mid_q),
        .data_q   (data_q),
        .mode_q   (mode_q)
    );

    assign dac_word = pick_data ? data_q : mid_q;
endmodule

// File: rtl/midscale_stuffer_chk.sv
module midscale_stuffer_chk
    import mstuf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic [WORD_W-1:0] smp_in,
    input logic              smp_vld,
    input logic              odd_ph,
    input logic              mode_q,
    input logic [WORD_W-1:0] dac_word
);
    assert_reset_mid_R1: assert property (@(posedge clk)
        !rst_n |=> (dac_word == MIDSCALE && !odd_ph));

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !odd_ph && smp_vld) |=> dac_word == $past(smp_in));

    assert_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && odd_ph && mode_q) |=> dac_word == MIDSCALE);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && odd_ph && !mode_q) |=> $stable(dac_word));

    assert_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !odd_ph && !smp_vld) |=> dac_word == MIDSCALE);

    assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(dac_word) && $stable(odd_ph)));

    assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> odd_ph != $past(odd_ph));
endmodule

bind midscale_stuffer midscale_stuffer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .smp_in   (smp_in),
    .smp_vld  (smp_vld),
    .odd_ph   (odd_ph),
    .mode_q   (mode_q),
    .dac_word (dac_word)
);

// File: tb/midscale_stuffer_bench.sv
module midscale_stuffer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic [13:0] smp_in = 14'h0;
    logic        smp_vld = 1'b0;
    logic        stuff_en = 1'b0;
    logic [13:0] dac_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    midscale_stuffer u_midscale_stuffer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .smp_in   (smp_in),
        .smp_vld  (smp_vld),
        .stuff_en (stuff_en),
        .dac_word (dac_word)
    );

    typedef struct packed {
        logic        en;
        logic        vld;
        logic        mode;
        logic [13:0] din;
        logic [13:0] exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b1, 14'h0111, 14'h0111}, // R2 capture
        '{1'b1, 1'b1, 1'b1, 14'h0555, 14'h2000}, // R3 fill, R7 odd input ignored
        '{1'b1, 1'b1, 1'b1, 14'h3FFF, 14'h3FFF}, // R2
        '{1'b1, 1'b0, 1'b1, 14'h0000, 14'h2000}, // R3, R9 after full-scale
        '{1'b1, 1'b1, 1'b0, 14'h0000, 14'h0000}, // R5 mode change with capture
        '{1'b1, 1'b1, 1'b1, 14'h0777, 14'h0000}, // R4 hold, R5 odd mode flip ignored, R7
        '{1'b1, 1'b1, 1'b0, 14'h1234, 14'h1234}, // R2
        '{1'b0, 1'b1, 1'b1, 14'h0AAA, 14'h1234}, // R8 stall mid pair
        '{1'b1, 1'b0, 1'b0, 14'h0000, 14'h1234}, // R4 after stall
        '{1'b1, 1'b0, 1'b1, 14'h0000, 14'h2000}, // R6 empty slot
        '{1'b1, 1'b0, 1'b0, 14'h0000, 14'h2000}, // R6 second slot, R5
        '{1'b1, 1'b1, 1'b1, 14'h2ABC, 14'h2ABC}, // R2
        '{1'b1, 1'b0, 1'b0, 14'h0000, 14'h2000}, // R3 with late mode flip, R5
        '{1'b1, 1'b1, 1'b0, 14'h1FFF, 14'h1FFF}, // R5
        '{1'b0, 1'b0, 1'b1, 14'h0000, 14'h1FFF}, // R8
        '{1'b1, 1'b0, 1'b1, 14'h0000, 14'h1FFF}, // R4
        '{1'b1, 1'b1, 1'b1, 14'h0001, 14'h0001}, // R2
        '{1'b1, 1'b0, 1'b1, 14'h0000, 14'h2000}  // R3, R9
    };

    task automatic check(input string req, input logic [13:0] exp);
        n_cmp++;
        if (dac_word !== exp) begin
            n_bad++;
            $display("FAIL %s: dac_word=%h expected=%h", req, dac_word, exp);
        end
    endtask

    task automatic drive(input logic en, input logic vld, input logic mode, input logic [13:0] d);
        clk_en = en; smp_vld = vld; stuff_en = mode; smp_in = d;
    endtask

    initial begin
        drive(1'b0, 1'b0, 1'b0, 14'h0);
        repeat (3) @(negedge clk);
        check("R1", 14'h2000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 14'h2000);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].en, VECS[i].vld, VECS[i].mode, VECS[i].din);
            @(negedge clk);
            check($sformatf("R2-R9 vec %0d", i), VECS[i].exp);
        end

        // reset in the middle of a pair: phase must restart even (R1)
        drive(1'b1, 1'b1, 1'b0, 14'h0F0F);
        @(negedge clk);
        check("R2", 14'h0F0F);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 14'h2000);
        rst_n = 1'b1;
        drive(1'b1, 1'b1, 1'b1, 14'h3C3C);
        @(negedge clk);
        check("R1", 14'h3C3C);
        drive(1'b1, 1'b1, 1'b1, 14'h0303);
        @(negedge clk);
        check("R3", 14'h2000);
        // long stuffing run: strict alternation, R3 and R9
        for (int k = 0; k < 8; k++) begin
            drive(1'b1, 1'b1, 1'b1, 14'(k * 1111));
            @(negedge clk);
            check("R2", 14'(k * 1111));
            drive(1'b1, 1'b1, 1'b1, 14'h3FFF);
            @(negedge clk);
            check("R9", 14'h2000);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule